// File: doc/BRIEF.md
# Descriptor Ring Walker for a Packet Controller

This block keeps two rings of buffer descriptors in a small internal store: a receive ring of eight entries and a transmit ring of two. Each descriptor holds a 16-bit status halfword, a 16-bit length and a 32-bit buffer index. Software fills and inspects the store through a word-addressed port. Ownership of a descriptor moves between software and the engine through one flag in the status halfword. On the transmit side that flag means "ready". On the receive side it means "empty".

On the transmit side, the engine presents the current descriptor as a request to a frame sender while the ring is active and the descriptor is ready. When the sender reports completion, the engine hands the descriptor back to software and records the retry count. On the receive side, the engine offers the current empty descriptor's buffer index to a frame source. When a finished frame arrives, it closes the descriptor with the length and the error flags. A ring goes idle when it meets a descriptor it does not own. It starts again only when software writes the poll key to that ring's activate address. Payload movement, CRC and the MAC itself sit outside this block.

Top module: `bd_ring_engine`

## Requirements
- R1: After reset every descriptor word reads 0, both rings are idle, `tx_req_valid` and `rx_ready` are 0 and `rx_overrun` is 0.
- R2: Descriptor `e` occupies words `2e` (status in bits 31:16, length in bits 15:0) and `2e+1` (buffer index). Receive entries are 0..7 and transmit entries are 8..9. A word written through the port reads back from the next cycle on. Any other address reads 0.
- R3: A write of 0x01000000 to address 30 activates the receive ring, and the same write to address 31 activates the transmit ring. Each write affects only its own ring. Any other value written to these addresses has no effect.
- R4: While the transmit ring is active and the current descriptor has status bit 15 (ready) set, `tx_req_valid` is 1. In that state `tx_req_len`, `tx_req_buf`, `tx_req_last` (status bit 11) and `tx_req_crc` (status bit 10) show that descriptor.
- R5: A `tx_done` while `tx_req_valid` is 1 rewrites the descriptor's status. Bit 15 is cleared, bits 5:2 take `tx_done_retry`, and all other bits are kept. The transmit index then advances. A `tx_done` at any other time is ignored.
- R6: A descriptor with status bit 13 (wrap) set is the last in its ring, so after it the index returns to 0. The physical last entry of a ring also returns the index to 0.
- R7: If a ring is active and its current descriptor is not owned by the engine (bit 15 clear), the ring goes idle on the next cycle. It stays idle, even if software then sets bit 15, until the next poll write.
- R8: A frame (`rx_frame_valid`) that arrives while `rx_ready` is 1 closes the current receive descriptor. Bit 15 (empty) is cleared, bits 5:0 take `rx_frame_err`, the length field takes `rx_frame_len` (which includes the 4-byte FCS), and the receive index advances.
- R9: A received frame longer than 1518 bytes is stored with length 1520, and status bit 5 is set in addition to the reported error bits.
- R10: A frame that arrives while `rx_ready` is 0 leaves every descriptor unchanged and sets the sticky `rx_overrun` flag. A receive poll write clears the flag unless another drop occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_we | input | 1 | Software write strobe |
| sw_addr | input | 5 | Software word address |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Read data for `sw_addr` |
| tx_req_valid | output | 1 | Current transmit descriptor is ready for sending |
| tx_req_len | output | 16 | Frame length of the request |
| tx_req_buf | output | 32 | Buffer index of the request |
| tx_req_last | output | 1 | Last-in-frame flag of the request |
| tx_req_crc | output | 1 | Append-CRC flag of the request |
| tx_done | input | 1 | Sender finished the requested frame |
| tx_done_retry | input | 4 | Retry count for the finished frame |
| rx_frame_valid | input | 1 | A received frame completes this cycle |
| rx_frame_len | input | 16 | Received length including FCS |
| rx_frame_err | input | 6 | Receive error flags |
| rx_ready | output | 1 | Receive ring can take a frame |
| rx_buf | output | 32 | Buffer index that the next frame fills |
| rx_overrun | output | 1 | Sticky: a frame was dropped |

## Verification
The hardest case to reach is a receive ring that has wrapped onto a descriptor software has not yet returned. The bench gets there by preparing only four empty descriptors, with wrap on the fourth, and sending four frames. The last of the four is oversized, which also covers the truncation rule. The engine then lands on the closed first entry and goes idle. The bench then sends more frames into the idle ring, re-empties the descriptor without polling, and finally polls, to show that overrun is raised and then cleared. A similar path on the transmit side makes a software write to a descriptor collide in the same cycle with the engine closing it.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
  localparam int ST_W      = 16;
  localparam int OWN_BIT   = 15; // ready (tx) / empty (rx)
  localparam int WRAP_BIT  = 13;
  localparam int LAST_BIT  = 11;
  localparam int CRC_BIT   = 10;
  localparam int RETRY_LO  = 2;
  localparam int RETRY_W   = 4;
  localparam int ERR_W     = 6;
  localparam int LONG_BIT  = 5;
  localparam logic [31:0] POLL_KEY = 32'h0100_0000;
endpackage

// File: rtl/bdr_desc_store.sv
module bdr_desc_store #(
  parameter int NE = 10,
  parameter int AW = 5,
  localparam int EW = (NE > 1) ? $clog2(NE) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_we,
  input  logic [AW-1:0] sw_addr,
  input  logic [31:0]   sw_wdata,
  output logic [31:0]   sw_rdata,
  input  logic          a_we,
  input  logic [EW-1:0] a_ent,
  input  logic [15:0]   a_st,
  input  logic [15:0]   a_ln,
  input  logic          b_we,
  input  logic [EW-1:0] b_ent,
  input  logic [15:0]   b_st,
  output logic [15:0]   st_o [NE],
  output logic [15:0]   ln_o [NE],
  output logic [31:0]   bf_o [NE]
);
  logic [15:0] st_q [NE];
  logic [15:0] ln_q [NE];
  logic [31:0] bf_q [NE];
  logic [15:0] st_n [NE];
  logic [15:0] ln_n [NE];
  logic [31:0] bf_n [NE];
  logic        mem_en;

  assign mem_en = sw_we | a_we | b_we;

  // Engine writes override a software write to the same field in the same cycle.
  always_comb begin
    st_n = st_q;
    ln_n = ln_q;
    bf_n = bf_q;
    for (int e = 0; e < NE; e++) begin
      if (sw_we && sw_addr == AW'(2*e)) begin
        st_n[e] = sw_wdata[31:16];
        ln_n[e] = sw_wdata[15:0];
      end
      if (sw_we && sw_addr == AW'(2*e+1)) bf_n[e] = sw_wdata;
      if (a_we && a_ent == EW'(e)) begin
        st_n[e] = a_st;
        ln_n[e] = a_ln;
      end
      if (b_we && b_ent == EW'(e)) st_n[e] = b_st;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NE; e++) begin
        st_q[e] <= '0;
        ln_q[e] <= '0;
        bf_q[e] <= '0;
      end
    end else if (mem_en) begin
      st_q <= st_n;
      ln_q <= ln_n;
      bf_q <= bf_n;
    end
  end

  always_comb begin
    sw_rdata = '0;
    for (int e = 0; e < NE; e++) begin
      if (sw_addr == AW'(2*e))   sw_rdata = {st_q[e], ln_q[e]};
      if (sw_addr == AW'(2*e+1)) sw_rdata = bf_q[e];
    end
  end

  assign st_o = st_q;
  assign ln_o = ln_q;
  assign bf_o = bf_q;
endmodule

// File: rtl/bdr_tx_walk.sv
module bdr_tx_walk
  import bdr_pkg::*;
#(
  parameter int N = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          poll,
  input  logic [15:0]   cur_st,
  input  logic          done,
  input  logic [3:0]    retry,
  output logic          active,
  output logic [IW-1:0] idx,
  output logic          req,
  output logic          we,
  output logic [15:0]   wst
);
  logic          act_q, act_n;
  logic [IW-1:0] idx_q, idx_n;
  logic          idx_en;

  always_comb begin
    req    = act_q && cur_st[OWN_BIT];
    we     = req && done;
    wst    = cur_st;
    wst[OWN_BIT] = 1'b0;
    wst[RETRY_LO +: RETRY_W] = retry;
    idx_en = we;
    idx_n  = (cur_st[WRAP_BIT] || idx_q == IW'(N-1)) ? '0 : idx_q + 1'b1;
    act_n  = act_q;
    if (act_q && !cur_st[OWN_BIT]) act_n = 1'b0;
    if (poll) act_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
    end else begin
      act_q <= act_n;
      if (idx_en) idx_q <= idx_n;
    end
  end

  assign active = act_q;
  assign idx    = idx_q;
endmodule

// File: rtl/bdr_rx_walk.sv
module bdr_rx_walk
  import bdr_pkg::*;
#(
  parameter int N         = 8,
  parameter int MAX_FRAME = 1518,
  parameter int MAX_BUF   = 1520,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          poll,
  input  logic [15:0]   cur_st,
  input  logic          frm_v,
  input  logic [15:0]   frm_len,
  input  logic [5:0]    frm_err,
  output logic          active,
  output logic [IW-1:0] idx,
  output logic          ready,
  output logic          we,
  output logic [15:0]   wst,
  output logic [15:0]   wln,
  output logic          overrun
);
  logic          act_q, act_n;
  logic [IW-1:0] idx_q, idx_n;
  logic          ov_q, ov_n;
  logic          drop, too_long;

  always_comb begin
    ready    = act_q && cur_st[OWN_BIT];
    we       = frm_v && ready;
    drop     = frm_v && !ready;
    too_long = frm_len > 16'(MAX_FRAME);
    wst      = cur_st;
    wst[OWN_BIT] = 1'b0;
    wst[ERR_W-1:0] = frm_err;
    if (too_long) wst[LONG_BIT] = 1'b1;
    wln      = too_long ? 16'(MAX_BUF) : frm_len;
    idx_n    = (cur_st[WRAP_BIT] || idx_q == IW'(N-1)) ? '0 : idx_q + 1'b1;
    act_n    = act_q;
    if (act_q && !cur_st[OWN_BIT]) act_n = 1'b0;
    if (poll) act_n = 1'b1;
    ov_n     = ov_q;
    if (poll) ov_n = 1'b0;
    if (drop) ov_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
      ov_q  <= 1'b0;
    end else begin
      act_q <= act_n;
      ov_q  <= ov_n;
      if (we) idx_q <= idx_n;
    end
  end

  assign active  = act_q;
  assign idx     = idx_q;
  assign overrun = ov_q;
endmodule

// File: rtl/bd_ring_engine.sv
module bd_ring_engine
  import bdr_pkg::*;
#(
  parameter int RX_N      = 8,
  parameter int TX_N      = 2,
  parameter int AW        = 5,
  parameter int MAX_FRAME = 1518,
  parameter int MAX_BUF   = 1520
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_we,
  input  logic [AW-1:0] sw_addr,
  input  logic [31:0]   sw_wdata,
  output logic [31:0]   sw_rdata,
  output logic          tx_req_valid,
  output logic [15:0]   tx_req_len,
  output logic [31:0]   tx_req_buf,
  output logic          tx_req_last,
  output logic          tx_req_crc,
  input  logic          tx_done,
  input  logic [3:0]    tx_done_retry,
  input  logic          rx_frame_valid,
  input  logic [15:0]   rx_frame_len,
  input  logic [5:0]    rx_frame_err,
  output logic          rx_ready,
  output logic [31:0]   rx_buf,
  output logic          rx_overrun
);
  localparam int NE  = RX_N + TX_N;
  localparam int EW  = (NE > 1) ? $clog2(NE) : 1;
  localparam int RIW = (RX_N > 1) ? $clog2(RX_N) : 1;
  localparam int TIW = (TX_N > 1) ? $clog2(TX_N) : 1;
  localparam logic [AW-1:0] RX_POLL_A = AW'((1 << AW) - 2);
  localparam logic [AW-1:0] TX_POLL_A = AW'((1 << AW) - 1);

  logic [15:0] st [NE];
  logic [15:0] ln [NE];
  logic [31:0] bf [NE];

  logic rx_poll, tx_poll;
  assign rx_poll = sw_we && sw_addr == RX_POLL_A && sw_wdata == POLL_KEY;
  assign tx_poll = sw_we && sw_addr == TX_POLL_A && sw_wdata == POLL_KEY;

  logic [RIW-1:0] rx_idx;
  logic [TIW-1:0] tx_idx;
  logic [EW-1:0]  rx_ent, tx_ent;
  assign rx_ent = EW'(rx_idx);
  assign tx_ent = EW'(RX_N) + EW'(tx_idx);

  logic        rx_act, rx_we, tx_act, tx_we;
  logic [15:0] rx_wst, rx_wln, tx_wst;

  bdr_desc_store #(.NE(NE), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .a_we(rx_we), .a_ent(rx_ent), .a_st(rx_wst), .a_ln(rx_wln),
    .b_we(tx_we), .b_ent(tx_ent), .b_st(tx_wst),
    .st_o(st), .ln_o(ln), .bf_o(bf)
  );

  bdr_tx_walk #(.N(TX_N)) u_tx (
    .clk(clk), .rst_n(rst_n), .poll(tx_poll), .cur_st(st[tx_ent]),
    .done(tx_done), .retry(tx_done_retry),
    .active(tx_act), .idx(tx_idx), .req(tx_req_valid), .we(tx_we), .wst(tx_wst)
  );

  bdr_rx_walk #(.N(RX_N), .MAX_FRAME(MAX_FRAME), .MAX_BUF(MAX_BUF)) u_rx (
    .clk(clk), .rst_n(rst_n), .poll(rx_poll), .cur_st(st[rx_ent]),
    .frm_v(rx_frame_valid), .frm_len(rx_frame_len), .frm_err(rx_frame_err),
    .active(rx_act), .idx(rx_idx), .ready(rx_ready), .we(rx_we),
    .wst(rx_wst), .wln(rx_wln), .overrun(rx_overrun)
  );

  assign tx_req_len  = ln[tx_ent];
  assign tx_req_buf  = bf[tx_ent];
  assign tx_req_last = st[tx_ent][LAST_BIT];
  assign tx_req_crc  = st[tx_ent][CRC_BIT];
  assign rx_buf      = bf[rx_ent];

  // R3
  rx_poll_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_poll |=> rx_act);
  // R7
  tx_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_act && !tx_poll) |=> !tx_req_valid);
  // R5
  tx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req_valid && tx_done) |=> !st[EW'(RX_N) + EW'($past(tx_idx))][OWN_BIT]);
  // R8
  rx_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_frame_valid && rx_ready) |=> !st[EW'($past(rx_idx))][OWN_BIT]);
  // R10
  rx_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_frame_valid && !rx_ready) |=> rx_overrun);
endmodule

// File: tb/sim_bd_ring_engine.sv
`timescale 1ns/1ps
module sim_bd_ring_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_we = 1'b0;
  logic [4:0]  sw_addr = '0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] sw_rdata;
  logic        tx_req_valid, tx_req_last, tx_req_crc;
  logic [15:0] tx_req_len;
  logic [31:0] tx_req_buf;
  logic        tx_done = 1'b0;
  logic [3:0]  tx_done_retry = '0;
  logic        rx_frame_valid = 1'b0;
  logic [15:0] rx_frame_len = '0;
  logic [5:0]  rx_frame_err = '0;
  logic        rx_ready, rx_overrun;
  logic [31:0] rx_buf;

  always #2 clk = ~clk;

  bd_ring_engine u0 (.*);

  int checks = 0, bad = 0;
  string phase = "R1 reset";

  // behavioural reference state
  int mst [10];
  int mln [10];
  int mbf [10];
  int rxa = 0, txa = 0, rxi = 0, txi = 0, ovr = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s [%s] actual=%h expected=%h", tag, phase, act, exp);
    end
  endtask

  function automatic logic [31:0] mread(int a);
    if (a < 20) return (a % 2 == 0) ? ((mst[a/2] << 16) | mln[a/2]) : mbf[a/2];
    return 32'h0;
  endfunction

  task automatic compare();
    int te;
    logic tv, rr;
    te = 8 + txi;
    tv = (txa != 0) && mst[te][15];
    rr = (rxa != 0) && mst[rxi][15];
    chk("R4/R7 tx_req_valid", 32'(tx_req_valid), 32'(tv));
    if (tv) begin
      chk("R4 tx_req_len", 32'(tx_req_len), mln[te]);
      chk("R4 tx_req_buf", tx_req_buf, mbf[te]);
      chk("R4 tx_req_last", 32'(tx_req_last), 32'(mst[te][11]));
      chk("R4 tx_req_crc", 32'(tx_req_crc), 32'(mst[te][10]));
    end
    chk("R8/R7 rx_ready", 32'(rx_ready), 32'(rr));
    if (rr) chk("R8 rx_buf", rx_buf, mbf[rxi]);
    chk("R10 rx_overrun", 32'(rx_overrun), ovr);
    chk("R2 sw_rdata", sw_rdata, mread(int'(sw_addr)));
  endtask

  task automatic model_step();
    int ter, tet, ost_r, ost_t;
    logic rrdy, tv, acc, drp, fire, pr, pt;
    ter = rxi; tet = 8 + txi;
    ost_r = mst[ter]; ost_t = mst[tet];
    rrdy = (rxa != 0) && ost_r[15];
    tv   = (txa != 0) && ost_t[15];
    acc  = rx_frame_valid && rrdy;
    drp  = rx_frame_valid && !rrdy;
    fire = tx_done && tv;
    pr = sw_we && sw_addr == 5'd30 && sw_wdata == 32'h0100_0000;
    pt = sw_we && sw_addr == 5'd31 && sw_wdata == 32'h0100_0000;
    if (sw_we && sw_addr < 5'd20) begin
      if (sw_addr[0] == 1'b0) begin
        mst[sw_addr/2] = sw_wdata[31:16];
        mln[sw_addr/2] = sw_wdata[15:0];
      end else mbf[sw_addr/2] = sw_wdata;
    end
    if (acc) begin
      mst[ter] = (ost_r & ~32'h803F) | rx_frame_err | ((rx_frame_len > 1518) ? 32'h20 : 0);
      mln[ter] = (rx_frame_len > 1518) ? 1520 : rx_frame_len;
      rxi = (ost_r[13] || rxi == 7) ? 0 : rxi + 1;
    end
    if (fire) begin
      mst[tet] = (ost_t & ~32'h803C) | (int'(tx_done_retry) << 2);
      txi = (ost_t[13] || txi == 1) ? 0 : txi + 1;
    end
    if (pr) rxa = 1; else if (rxa != 0 && !ost_r[15]) rxa = 0;
    if (pt) txa = 1; else if (txa != 0 && !ost_t[15]) txa = 0;
    if (pr) ovr = 0;
    if (drp) ovr = 1;
  endtask

  task automatic cyc();
    #1 compare();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic wr(int a, logic [31:0] d);
    sw_we = 1'b1; sw_addr = 5'(a); sw_wdata = d;
    cyc();
    sw_we = 1'b0;
  endtask

  task automatic rd(int a);
    sw_addr = 5'(a);
    cyc();
  endtask

  task automatic txfin(logic [3:0] r);
    tx_done = 1'b1; tx_done_retry = r;
    cyc();
    tx_done = 1'b0;
  endtask

  task automatic rxfrm(int len, logic [5:0] err);
    rx_frame_valid = 1'b1; rx_frame_len = 16'(len); rx_frame_err = err;
    cyc();
    rx_frame_valid = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog [%s] actual=running expected=finished", phase);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    for (int e = 0; e < 10; e++) begin mst[e] = 0; mln[e] = 0; mbf[e] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: all words zero, rings idle
    for (int a = 0; a < 32; a++) rd(a);

    phase = "R2 descriptor port";
    for (int e = 0; e < 4; e++) begin
      wr(2*e, (e == 3) ? 32'hA000_0000 : 32'h8000_0000);
      wr(2*e+1, 32'h100 + e);
    end
    wr(16, 32'h8C00_0040);      // tx0 ready|last|crc, len 64
    wr(17, 32'hB000_0000);
    wr(18, 32'h2000_0064);      // tx1 wrap, not ready
    wr(19, 32'hB000_0001);
    for (int a = 0; a < 20; a++) rd(a);

    phase = "R3 poll key";
    wr(31, 32'h0000_0001);
    wr(30, 32'h0100_0001);
    rd(16); rd(16);
    wr(31, 32'h0100_0000);
    rd(16); rd(16);

    phase = "R5 tx completion";
    txfin(4'd5);
    rd(16); rd(16);

    phase = "R7 idle until poll";
    wr(18, 32'hA800_0064);
    rd(18); rd(18); rd(18);
    wr(31, 32'h0100_0000);
    rd(18);
    phase = "R6 tx wrap";
    txfin(4'd0);
    rd(18); rd(16); rd(16);

    phase = "R5 collision";
    wr(16, 32'h8400_0080);
    wr(31, 32'h0100_0000);
    sw_we = 1'b1; sw_addr = 5'd16; sw_wdata = 32'h1234_0005;
    tx_done = 1'b1; tx_done_retry = 4'd15;
    cyc();
    sw_we = 1'b0; tx_done = 1'b0;
    rd(16); rd(16);

    phase = "R8 rx close";
    wr(30, 32'h0100_0000);
    rxfrm(64, 6'd0);
    rd(0);
    rxfrm(200, 6'h03);
    rd(2);
    rxfrm(1518, 6'd0);
    rd(4);
    phase = "R9 oversize";
    rxfrm(1600, 6'h01);
    rd(6); rd(6);
    phase = "R10 overrun";
    rxfrm(90, 6'd0);
    rd(0);
    wr(0, 32'h8000_0000);
    rxfrm(91, 6'd0);
    rd(0);
    wr(30, 32'h0100_0000);
    rxfrm(120, 6'h02);
    rd(0); rd(2); rd(2);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule